// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Select Override

This block owns a small group of shared pads that carry configuration levels while the device comes out of power-on reset. For as long as reset is held, it samples the pad levels into a five-bit strap register on every clock edge. Once reset is released, the register freezes, a short turnaround window passes with the pads still undriven, and the pads are then handed over to their clock-output role.

From the frozen straps and one control byte written over the serial interface, the block forms the effective frequency-select word used by the synthesizer. A mode bit in the control byte picks the source: either the four latched select straps, or a five-bit software code held in the same byte. The selected word is registered, so it only moves on a clock edge. The straps are also reported back in inverted form, and the fifth strap picks the auxiliary clock rate.

The sequencer has three named states. CAPTURE is entered whenever reset is low, and the straps follow the pads there. The transition CAPTURE to TURN happens on the first edge with reset high. TURN lasts `TURN_CYC` cycles with the pads still undriven. The transition TURN to RUN then enables the pad drivers, and RUN holds until reset is asserted again, which returns the block to CAPTURE.

Top module: `strap_latch`

## Requirements
- R1: On every rising clock edge with `por_n` low, the strap register loads `pad_in`; the value sampled at the last such edge is the one kept.
- R2: While `por_n` stays high, changes on `pad_in` have no effect on the strap register, `strap_rb` or `aux_24m`.
- R3: `strap_rb` is the bitwise inverse of the strap register: bits 0 to 3 carry select straps 0 to 3 and bit 4 carries the auxiliary-rate strap.
- R4: `pad_oe` is all zeros while `por_n` is low and for `TURN_CYC` clock edges after the first edge with `por_n` high; after the next edge it is all ones (state RUN).
- R5: `aux_24m` equals strap bit 4: 1 selects the 24 MHz auxiliary rate, 0 selects 48 MHz.
- R6: With `cfg_byte[3]` = 0, one edge later `freq_sel` equals strap bits 3:0 and `freq_ext` is 0.
- R7: With `cfg_byte[3]` = 1, one edge later `freq_sel` equals `cfg_byte[7:4]` and `freq_ext` equals `cfg_byte[2]`.
- R8: `freq_sel`, `freq_ext` and `spread_on` change only on a rising clock edge; a change of `cfg_byte` between edges leaves them unchanged.
- R9: `spread_on` follows `cfg_byte[1]` one edge later, whatever source the frequency code uses.
- R10: With `cfg_byte[0]` = 1, `pad_oe` is all zeros and `drv_en` is 0 at once, with no clock edge needed.
- R11: Taking `por_n` low again after RUN returns the sequencer to CAPTURE, clears `pad_oe` after one edge and re-arms the strap capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous to `clk` |
| pad_in | input | 5 | Levels seen on the shared pads |
| cfg_byte | input | 8 | Control byte: [0] tristate all, [1] spread enable, [2] code extension, [3] software select, [7:4] software code |
| pad_oe | output | 5 | Output enable for each shared pad |
| drv_en | output | 1 | Output enable for all other clock outputs |
| strap_rb | output | 5 | Inverted strap readback |
| aux_24m | output | 1 | Auxiliary clock rate: 1 = 24 MHz, 0 = 48 MHz |
| freq_sel | output | 4 | Effective frequency-select code |
| freq_ext | output | 1 | Fifth frequency-select bit, software mode only |
| spread_on | output | 1 | Spread modulation enable |

## Verification
The bench changes the pads between edges during reset, so a capture that held the first sample instead of the last would report stale straps. It also drives the pads after release, which a latch left open would follow. It counts the turnaround edges to the exact cycle: an off-by-one counter would enable the pads one edge early or late and contend with the strap resistors. Between edges it flips the mode bit to catch an unregistered code mux that would glitch the frequency word. It also re-enters reset from RUN to confirm that a second capture takes fresh straps rather than staying frozen.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_TURN    = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_t;

    // control byte field positions
    localparam int CFG_HIZ    = 0;
    localparam int CFG_SPREAD = 1;
    localparam int CFG_EXT    = 2;
    localparam int CFG_MODE   = 3;
    localparam int CFG_CODE_L = 4;
    localparam int CFG_CODE_H = 7;

    localparam int FS_W    = 4;
    localparam int STRAP_W = FS_W + 1;
    localparam int AUX_BIT = FS_W;

    typedef struct packed {
        logic             spread;
        logic             ext;
        logic [FS_W-1:0]  sel;
    } freq_word_t;

endpackage

// File: rtl/strap_seq.sv
module strap_seq
    import strap_pkg::*;
#(
    parameter int TURN_CYC = 4
) (
    input  logic       clk,
    input  logic       por_n,
    output seq_state_t state,
    output logic       run_o
);

    localparam int CNT_W = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TURN_CYC - 1);

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            state <= ST_CAPTURE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_CAPTURE: begin
                nxt     = ST_TURN;
                cnt_nxt = '0;
            end
            ST_TURN: begin
                if (cnt == CNT_LAST) nxt = ST_RUN;
                else                 cnt_nxt = cnt + 1'b1;
            end
            ST_RUN: nxt = ST_RUN;
            default: nxt = ST_CAPTURE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:  run_o = 1'b1;
            default: run_o = 1'b0;
        endcase
    end

    // R4: first edge with reset high moves to the turnaround state
    assert_enter_turn_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |=> (state == ST_TURN));

    // R4: once driving, only a reset leaves RUN
    assert_run_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN) |=> (state == ST_RUN));

endmodule

// File: rtl/strap_bank.sv
module strap_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] strap_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!por_n) strap_q[i] <= pad_in[i];
        end
    end

    // R1: value held after release is the last sample taken in reset
    assert_last_sample_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (strap_q == $past(pad_in)));

    // R2: frozen while reset stays released
    assert_frozen_R2: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> $stable(strap_q));

endmodule

// File: rtl/freq_code_sel.sv
module freq_code_sel
    import strap_pkg::*;
(
    input  logic            clk,
    input  logic            por_n,
    input  logic [FS_W-1:0] strap_fs,
    input  logic [7:0]      cfg_byte,
    output freq_word_t      word_q
);

    freq_word_t word_d;

    always_comb begin
        word_d.spread = cfg_byte[CFG_SPREAD];
        if (cfg_byte[CFG_MODE]) begin
            word_d.ext = cfg_byte[CFG_EXT];
            word_d.sel = cfg_byte[CFG_CODE_H:CFG_CODE_L];
        end else begin
            word_d.ext = 1'b0;
            word_d.sel = strap_fs;
        end
    end

    always_ff @(posedge clk) word_q <= word_d;

    // R7: software source
    assert_sw_code_R7: assert property (@(posedge clk) disable iff (!por_n)
        $past(cfg_byte[CFG_MODE]) |->
            (word_q.sel == $past(cfg_byte[CFG_CODE_H:CFG_CODE_L])) &&
            (word_q.ext == $past(cfg_byte[CFG_EXT])));

    // R6: strap source
    assert_strap_code_R6: assert property (@(posedge clk) disable iff (!por_n)
        !$past(cfg_byte[CFG_MODE]) |->
            (word_q.sel == $past(strap_fs)) && !word_q.ext);

    // R9: spread follows its bit one edge later
    assert_spread_R9: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (word_q.spread == $past(cfg_byte[CFG_SPREAD])));

endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_pkg::*;
#(
    parameter int TURN_CYC = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] pad_in,
    input  logic [7:0]         cfg_byte,
    output logic [STRAP_W-1:0] pad_oe,
    output logic               drv_en,
    output logic [STRAP_W-1:0] strap_rb,
    output logic               aux_24m,
    output logic [FS_W-1:0]    freq_sel,
    output logic               freq_ext,
    output logic               spread_on
);

    seq_state_t          state;
    logic                run;
    logic [STRAP_W-1:0]  strap_q;
    freq_word_t          word_q;

    strap_seq #(.TURN_CYC(TURN_CYC)) u_seq (
        .clk   (clk),
        .por_n (por_n),
        .state (state),
        .run_o (run)
    );

    strap_bank #(.W(STRAP_W)) u_bank (
        .clk     (clk),
        .por_n   (por_n),
        .pad_in  (pad_in),
        .strap_q (strap_q)
    );

    freq_code_sel u_code (
        .clk      (clk),
        .por_n    (por_n),
        .strap_fs (strap_q[FS_W-1:0]),
        .cfg_byte (cfg_byte),
        .word_q   (word_q)
    );

    assign drv_en    = ~cfg_byte[CFG_HIZ];
    assign pad_oe    = {STRAP_W{run & drv_en}};
    assign strap_rb  = ~strap_q;
    assign aux_24m   = strap_q[AUX_BIT];
    assign freq_sel  = word_q.sel;
    assign freq_ext  = word_q.ext;
    assign spread_on = word_q.spread;

    // R4: pads stay undriven right after release
    assert_oe_after_release_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |=> (pad_oe == '0));

    // R10: tristate request wins over the sequencer
    assert_hiz_R10: assert property (@(posedge clk) disable iff (!por_n)
        cfg_byte[CFG_HIZ] |-> (pad_oe == '0) && !drv_en);

    // R11: pads are driven only in RUN
    assert_oe_run_only_R11: assert property (@(posedge clk) disable iff (!por_n)
        (pad_oe != '0) |-> (state == ST_RUN));

endmodule

// File: tb/strap_latch_bench.sv
`timescale 1ns/100ps
module strap_latch_bench;

    localparam int TURN = 4;

    logic       clk = 1'b0;
    logic       por_n;
    logic [4:0] pad_in;
    logic [7:0] cfg_byte;
    logic [4:0] pad_oe;
    logic       drv_en;
    logic [4:0] strap_rb;
    logic       aux_24m;
    logic [3:0] freq_sel;
    logic       freq_ext;
    logic       spread_on;

    always #2.5 clk = ~clk;

    strap_latch #(.TURN_CYC(TURN)) u_strap_latch (
        .clk(clk), .por_n(por_n), .pad_in(pad_in), .cfg_byte(cfg_byte),
        .pad_oe(pad_oe), .drv_en(drv_en), .strap_rb(strap_rb), .aux_24m(aux_24m),
        .freq_sel(freq_sel), .freq_ext(freq_ext), .spread_on(spread_on)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic [31:0] due;
        logic [5:0]  exp;
        logic [7:0]  req;
    } item_t;

    item_t sb_q[$];
    item_t it;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares the registered frequency word against the queue
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            it = sb_q.pop_front();
            check($sformatf("R%0d", it.req), {26'd0, spread_on, freq_ext, freq_sel}, {26'd0, it.exp});
        end
    end

    // driver: new control byte, expected word one edge later; R8 checked between edges
    task automatic drive_cfg(input logic [7:0] v, input logic [5:0] exp, input int r);
        logic [5:0] prev;
        @(negedge clk);
        prev = {spread_on, freq_ext, freq_sel};
        cfg_byte = v;
        sb_q.push_back('{due: cyc + 1, exp: exp, req: r[7:0]});
        #1;
        check("R8", {26'd0, spread_on, freq_ext, freq_sel}, {26'd0, prev});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        por_n    = 1'b0;
        pad_in   = 5'b10110;
        cfg_byte = 8'h00;
        repeat (3) @(negedge clk);
        check("R4 oe in reset", {27'd0, pad_oe}, 32'h0);
        check("R10 drv_en default", {31'd0, drv_en}, 32'h1);

        // R1: capture follows the pads; last sample kept
        pad_in = 5'b01001;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        for (int i = 0; i < TURN; i++) begin
            @(negedge clk);
            check("R4 turnaround", {27'd0, pad_oe}, 32'h0);
        end
        check("R1 R3 readback", {27'd0, strap_rb}, 32'h16);
        check("R5 aux 48MHz", {31'd0, aux_24m}, 32'h0);
        @(negedge clk);
        check("R4 run", {27'd0, pad_oe}, 32'h1f);

        // R2: pads moving after release are ignored
        pad_in = 5'b11111;
        repeat (3) @(negedge clk);
        check("R2 frozen", {27'd0, strap_rb}, 32'h16);
        check("R2 aux frozen", {31'd0, aux_24m}, 32'h0);

        drive_cfg(8'b0000_0000, 6'b001001, 6);   // R6 strap source
        drive_cfg(8'b1011_1100, 6'b011011, 7);   // R7 software source
        drive_cfg(8'b0110_1010, 6'b100110, 9);   // R9 spread with software code
        drive_cfg(8'b0110_0010, 6'b101001, 6);   // R6 back to straps, spread kept

        // R10: tristate takes effect without an edge
        drive_cfg(8'b0000_0001, 6'b001001, 10);
        check("R10 pad_oe", {27'd0, pad_oe}, 32'h0);
        check("R10 drv_en", {31'd0, drv_en}, 32'h0);
        drive_cfg(8'b0000_0000, 6'b001001, 10);
        check("R10 release", {27'd0, pad_oe}, 32'h1f);

        // R11: reset again re-arms capture
        @(negedge clk);
        por_n  = 1'b0;
        pad_in = 5'b11111;
        @(negedge clk);
        check("R11 oe cleared", {27'd0, pad_oe}, 32'h0);
        check("R11 recapture", {27'd0, strap_rb}, 32'h0);
        pad_in = 5'b10110;
        @(negedge clk);
        por_n = 1'b1;
        repeat (TURN + 1) @(negedge clk);
        check("R11 readback", {27'd0, strap_rb}, 32'h09);
        check("R5 aux 24MHz", {31'd0, aux_24m}, 32'h1);
        check("R11 run again", {27'd0, pad_oe}, 32'h1f);
        drive_cfg(8'b0000_0000, 6'b000110, 11);   // R11 strap code from new sample

        wait (sb_q.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule